// File: doc/BRIEF.md
# UART Interrupt Condition Generator

This block turns the state that surrounds a UART's data path into interrupt requests. It watches the transmit and receive FIFO fill levels, the write strobe into the transmit holding stage, the read strobe out of the receive stage, the character-arrival strobe, a bit-period tick and the modem handshake lines. From these it keeps four raw interrupt conditions: transmit, receive, modem status and receive timeout. A single mode input selects how the transmit and receive conditions are formed. In FIFO mode they compare the fill level against half the FIFO depth. In single-register mode they follow whether the holding register is empty and whether the receive buffer is full.

Each raw condition has its own enable. The masked transmit and masked receive conditions drive their own request lines. A combined request line is the OR of all four masked conditions. The modem-status condition is sticky, and a clear strobe removes it. The receive-timeout condition is also sticky and stays set until the receive FIFO has been emptied. The serializer, deserializer, baud generator and the FIFOs themselves are outside this block.

Top module: `uart_irq_gen`

## Requirements
- R1: In FIFO mode (fifoMode=1), rawStatus[0] (transmit) equals (txLevel < FIFO_DEPTH/2) as sampled at the previous rising edge.
- R2: In single-register mode (fifoMode=0), rawStatus[0] is 1 one edge after a cycle with txLevel==0 and thrWrite=0. A cycle with thrWrite=1 gives 0 at the next edge.
- R3: In FIFO mode, rawStatus[1] (receive) equals (rxLevel >= FIFO_DEPTH/2) as sampled at the previous rising edge.
- R4: In single-register mode, rawStatus[1] is 1 one edge after a cycle with rxLevel!=0 and rxRead=0. A cycle with rxRead=1 gives 0 at the next edge.
- R5: A change on any bit of modemIn passes a two-flop synchronizer and sets rawStatus[2] at the third rising edge after the change. The bit stays set until a cycle with msClear=1. A change detected in the same cycle as msClear wins, so the bit stays set.
- R6: rawStatus[3] (timeout) is set on the TIMEOUT_BITS-th bitTick counted while rxLevel!=0. The count restarts on any cycle with rxPush, with rxRead, or with rxLevel==0.
- R7: Once set, rawStatus[3] stays set through pushes and reads while rxLevel!=0. It clears at the edge after a cycle with rxLevel==0.
- R8: The bit order is 0 transmit, 1 receive, 2 modem, 3 timeout. maskedStatus equals rawStatus & irqEnable, with no added latency. irqTx is maskedStatus[0], irqRx is maskedStatus[1], and irqAll is the OR of the four masked bits.
- R9: While rstN is low, rawStatus, maskedStatus and all three request lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoMode | input | 1 | 1 selects FIFO-level rules, 0 selects single-register rules |
| txLevel | input | LVL_W | Transmit FIFO fill level (holding register occupancy in single-register mode) |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| thrWrite | input | 1 | Write strobe into the transmit side |
| rxRead | input | 1 | Read strobe from the receive side |
| rxPush | input | 1 | A new character arrived in the receive FIFO |
| bitTick | input | 1 | One pulse per serial bit period |
| modemIn | input | MODEM_W | Asynchronous modem handshake lines |
| msClear | input | 1 | Clears the modem-status condition |
| irqEnable | input | 4 | Per-condition enables, same bit order as rawStatus |
| rawStatus | output | 4 | Unmasked conditions |
| maskedStatus | output | 4 | Conditions after enable |
| irqTx | output | 1 | Transmit request line |
| irqRx | output | 1 | Receive request line |
| irqAll | output | 1 | Combined request line |

## Verification
The bench builds the block with FIFO_DEPTH=8 and keeps TIMEOUT_BITS at 32. With that depth, every fill level from empty to full can be swept in both modes, with and without the clearing strobes, and each result is compared against the level-versus-threshold arithmetic. The 32-tick timeout is walked tick by tick, so the edge at tick 31 and tick 32 is checked, as are the restart on arrival and the stickiness rule. All sixteen enable patterns are applied with every raw condition set, which covers the masking and the combined line completely.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Bit positions inside the status vectors
  localparam int IDX_TX = 0;
  localparam int IDX_RX = 1;
  localparam int IDX_MS = 2;
  localparam int IDX_RT = 3;
  localparam int NUM_IRQ = 4;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic txWrite;
    logic rxRead;
    logic rxEmpty;
    logic modemChange;
    logic msClear;
    logic timeoutHit;
  } irqStrobes_t;

endpackage

// File: rtl/uart_irq_sync.sv
module uart_irq_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= asyncIn[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign syncOut = stage2;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH   = 16,
  parameter int TIMEOUT_BITS = 32,
  parameter int MODEM_W      = 4,
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1),
  localparam int CNT_W       = $clog2(TIMEOUT_BITS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic               thrWrite,
  input  logic               rxRead,
  input  logic               rxPush,
  input  logic               bitTick,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic               msClear,
  output irqStrobes_t        strobes
);

  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TIMEOUT_BITS - 1);

  logic [MODEM_W-1:0] modemSync;
  logic [MODEM_W-1:0] modemPrev;
  logic [CNT_W-1:0]   idleCnt;
  logic               rxEmpty;
  logic               counting;

  // Modem lines: synchronize, then compare against last synchronized value
  uart_irq_sync #(.WIDTH(MODEM_W)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (modemIn),
    .syncOut (modemSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) modemPrev <= '0;
    else       modemPrev <= modemSync;
  end

  // Receive idle counter in bit periods
  assign rxEmpty  = (rxLevel == '0);
  assign counting = !rxEmpty && !rxPush && !rxRead;

  always_ff @(posedge clk) begin
    if (!rstN || !counting) begin
      idleCnt <= '0;
    end else if (bitTick && idleCnt != CNT_LIMIT) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.txWrite     = thrWrite;
    strobes.rxRead      = rxRead;
    strobes.rxEmpty     = rxEmpty;
    strobes.modemChange = (modemSync != modemPrev);
    strobes.msClear     = msClear;
    strobes.timeoutHit  = counting && bitTick && (idleCnt == CNT_LAST);
  end

  // R6: counter never runs past the limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= CNT_LIMIT);

  // R6: an arrival restarts the count
  a_r6_push_restart: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> idleCnt == '0);

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoMode,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxLevel,
  input  irqStrobes_t        strobes,
  input  logic [NUM_IRQ-1:0] irqEnable,
  output logic [NUM_IRQ-1:0] rawStatus,
  output logic [NUM_IRQ-1:0] maskedStatus
);

  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(FIFO_DEPTH / 2);

  logic txRaw, rxRaw, msRaw, rtRaw;
  logic txNext, rxNext;

  always_comb begin
    if (fifoMode) begin
      txNext = (txLevel < HALF_LVL);
      rxNext = (rxLevel >= HALF_LVL);
    end else begin
      txNext = !strobes.txWrite && (txLevel == '0);
      rxNext = !strobes.rxRead  && (rxLevel != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txRaw <= 1'b0;
      rxRaw <= 1'b0;
    end else begin
      txRaw <= txNext;
      rxRaw <= rxNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    msRaw <= 1'b0;
    else if (strobes.modemChange) msRaw <= 1'b1;
    else if (strobes.msClear)     msRaw <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   rtRaw <= 1'b0;
    else if (strobes.rxEmpty)    rtRaw <= 1'b0;
    else if (strobes.timeoutHit) rtRaw <= 1'b1;
  end

  always_comb begin
    rawStatus         = '0;
    rawStatus[IDX_TX] = txRaw;
    rawStatus[IDX_RX] = rxRaw;
    rawStatus[IDX_MS] = msRaw;
    rawStatus[IDX_RT] = rtRaw;
  end

  assign maskedStatus = rawStatus & irqEnable;

  // R1: a FIFO at or above half never requests transmit service next cycle
  a_r1_tx_full_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && txLevel >= HALF_LVL) |=> !rawStatus[IDX_TX]);

  // R2: a write in single-register mode removes the transmit request
  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && strobes.txWrite) |=> !rawStatus[IDX_TX]);

  // R5: modem condition holds until cleared
  a_r5_ms_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rawStatus[IDX_MS] && !strobes.msClear) |=> rawStatus[IDX_MS]);

  // R7: an empty receive FIFO drops the timeout
  a_r7_rt_drop: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxEmpty |=> !rawStatus[IDX_RT]);

  // R7: timeout holds while data remains
  a_r7_rt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rawStatus[IDX_RT] && !strobes.rxEmpty) |=> rawStatus[IDX_RT]);

  // R8: a masked bit needs both its raw condition and its enable
  a_r8_mask: assert property (@(posedge clk) disable iff (!rstN)
    maskedStatus != '0 |-> irqEnable != '0);

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH   = 16,
  parameter int TIMEOUT_BITS = 32,
  parameter int MODEM_W      = 4,
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoMode,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic               thrWrite,
  input  logic               rxRead,
  input  logic               rxPush,
  input  logic               bitTick,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic               msClear,
  input  logic [3:0]         irqEnable,
  output logic [3:0]         rawStatus,
  output logic [3:0]         maskedStatus,
  output logic               irqTx,
  output logic               irqRx,
  output logic               irqAll
);

  irqStrobes_t strobes;

  uart_irq_ctrl #(
    .FIFO_DEPTH   (FIFO_DEPTH),
    .TIMEOUT_BITS (TIMEOUT_BITS),
    .MODEM_W      (MODEM_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxLevel  (rxLevel),
    .thrWrite (thrWrite),
    .rxRead   (rxRead),
    .rxPush   (rxPush),
    .bitTick  (bitTick),
    .modemIn  (modemIn),
    .msClear  (msClear),
    .strobes  (strobes)
  );

  uart_irq_dp #(
    .FIFO_DEPTH (FIFO_DEPTH)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .fifoMode     (fifoMode),
    .txLevel      (txLevel),
    .rxLevel      (rxLevel),
    .strobes      (strobes),
    .irqEnable    (irqEnable),
    .rawStatus    (rawStatus),
    .maskedStatus (maskedStatus)
  );

  assign irqTx  = maskedStatus[IDX_TX];
  assign irqRx  = maskedStatus[IDX_RX];
  assign irqAll = |maskedStatus;

  // R8: combined line is low only when every masked line is low
  a_r8_all_low: assert property (@(posedge clk) disable iff (!rstN)
    !irqAll |-> (!irqTx && !irqRx && maskedStatus == '0));

endmodule

// File: tb/test_uart_irq_gen.sv
`timescale 1ns/100ps
module test_uart_irq_gen;

  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;
  localparam int TOUT  = 32;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoMode = 1'b1;
  logic [LW-1:0] txLevel = '0;
  logic [LW-1:0] rxLevel = '0;
  logic thrWrite = 1'b0, rxRead = 1'b0, rxPush = 1'b0, bitTick = 1'b0;
  logic [3:0] modemIn = '0;
  logic msClear = 1'b0;
  logic [3:0] irqEnable = '0;
  logic [3:0] rawStatus, maskedStatus;
  logic irqTx, irqRx, irqAll;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  uart_irq_gen #(.FIFO_DEPTH(DEPTH), .TIMEOUT_BITS(TOUT), .MODEM_W(4)) i_uart_irq_gen (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .txLevel(txLevel), .rxLevel(rxLevel),
    .thrWrite(thrWrite), .rxRead(rxRead), .rxPush(rxPush), .bitTick(bitTick),
    .modemIn(modemIn), .msClear(msClear), .irqEnable(irqEnable),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus),
    .irqTx(irqTx), .irqRx(irqRx), .irqAll(irqAll)
  );

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // one cycle: inputs already set at a falling edge, result sampled at the next falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bitTick = 1'b1;
      cyc();
      bitTick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    irqEnable = 4'hF;
    modemIn = 4'h5;
    cyc(); cyc();
    // R9: reset state
    chk("R9 raw", int'(rawStatus), 0);
    chk("R9 masked", int'(maskedStatus), 0);
    chk("R9 lines", int'({irqTx, irqRx, irqAll}), 0);
    modemIn = '0;
    cyc(); cyc(); cyc();
    rstN = 1'b1;
    irqEnable = '0;

    // R1 / R2: transmit sweep
    for (int m = 0; m < 2; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int lv = 0; lv <= DEPTH; lv++) begin
          fifoMode = m[0];
          thrWrite = w[0];
          txLevel = LW'(lv);
          cyc();
          if (m == 1) chk("R1 tx fifo", int'(rawStatus[0]), (lv < HALF) ? 1 : 0);
          else        chk("R2 tx single", int'(rawStatus[0]), (lv == 0 && w == 0) ? 1 : 0);
        end
      end
    end
    thrWrite = 1'b0;

    // R3 / R4: receive sweep
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 2; r++) begin
        for (int lv = 0; lv <= DEPTH; lv++) begin
          fifoMode = m[0];
          rxRead = r[0];
          rxLevel = LW'(lv);
          cyc();
          if (m == 1) chk("R3 rx fifo", int'(rawStatus[1]), (lv >= HALF) ? 1 : 0);
          else        chk("R4 rx single", int'(rawStatus[1]), (lv != 0 && r == 0) ? 1 : 0);
        end
      end
    end
    rxRead = 1'b0;
    rxLevel = '0;
    fifoMode = 1'b1;
    cyc();

    // R5: modem change latency, stickiness, clear, set-wins
    chk("R5 idle", int'(rawStatus[2]), 0);
    for (int b = 0; b < 4; b++) begin
      modemIn[b] = ~modemIn[b];
      cyc(); cyc();
      chk("R5 not yet", int'(rawStatus[2]), 0);
      cyc();
      chk("R5 set", int'(rawStatus[2]), 1);
      cyc(); cyc();
      chk("R5 sticky", int'(rawStatus[2]), 1);
      msClear = 1'b1;
      cyc();
      msClear = 1'b0;
      chk("R5 cleared", int'(rawStatus[2]), 0);
    end
    modemIn = 4'h0;
    cyc(); cyc();
    msClear = 1'b1;
    cyc();
    msClear = 1'b0;
    chk("R5 set wins over clear", int'(rawStatus[2]), 1);
    msClear = 1'b1;
    cyc();
    msClear = 1'b0;
    cyc(); cyc();
    chk("R5 stays clear", int'(rawStatus[2]), 0);

    // R6: ticks with an empty FIFO do not count
    rxLevel = '0;
    ticks(TOUT + 4);
    chk("R6 empty no timeout", int'(rawStatus[3]), 0);
    rxLevel = LW'(1);
    ticks(TOUT - 1);
    chk("R6 one short", int'(rawStatus[3]), 0);
    ticks(1);
    chk("R6 expires", int'(rawStatus[3]), 1);
    // R7: sticky through push and read
    rxPush = 1'b1; cyc(); rxPush = 1'b0;
    rxRead = 1'b1; cyc(); rxRead = 1'b0;
    chk("R7 sticky", int'(rawStatus[3]), 1);
    rxLevel = '0;
    cyc();
    chk("R7 drained", int'(rawStatus[3]), 0);
    // R6: restart on arrival and on read
    rxLevel = LW'(2);
    ticks(20);
    rxPush = 1'b1; cyc(); rxPush = 1'b0;
    ticks(TOUT - 1);
    chk("R6 push restarts", int'(rawStatus[3]), 0);
    rxRead = 1'b1; cyc(); rxRead = 1'b0;
    ticks(TOUT - 1);
    chk("R6 read restarts", int'(rawStatus[3]), 0);
    ticks(1);
    chk("R6 expires after read", int'(rawStatus[3]), 1);

    // R8: every raw set, sweep all enables
    txLevel = '0;
    rxLevel = LW'(DEPTH);
    modemIn = 4'h8;
    cyc(); cyc(); cyc();
    chk("R8 raw all set", int'(rawStatus), 15);
    for (int e = 0; e < 16; e++) begin
      irqEnable = 4'(e);
      #1;
      chk("R8 masked", int'(maskedStatus), e);
      chk("R8 tx line", int'(irqTx), e & 1);
      chk("R8 rx line", int'(irqRx), (e >> 1) & 1);
      chk("R8 combined", int'(irqAll), (e != 0) ? 1 : 0);
      @(negedge clk);
    end
    // R8: combined follows a single source dropping out
    irqEnable = 4'b0100;
    msClear = 1'b1;
    cyc();
    msClear = 1'b0;
    chk("R8 combined drops", int'(irqAll), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule